// File: doc/BRIEF.md
# Bus Event Interrupt Status Latch

This block turns three kinds of bus event into sticky interrupt status bits. The events are a target dropping the connection when it should not have, a bus reset, and a parity fault. Each bit stays set until software reads the status, and the read clears them. An interrupt request is raised whenever a set bit is also enabled in the mask.

A disconnect counts as unexpected only while the controller acts as initiator. In script-execution mode, the block remembers whether the last received message byte announced the disconnect. A byte of 0x04 (disconnect notice) or 0x00 (transfer done) makes the next disconnect expected. In low-level mode every disconnect is reported. The bus reset line passes through a synchronizer and is detected on its rising edge, so a reset that is held long produces one event only. A reset the controller drives itself counts the same way. Parity faults, from either direction of transfer, are reported only while parity checking is enabled.

All pins are plain control and status signals. The block has no data stream, so it has no valid/ready handshake.

Top module: `bus_event_irq`

## Requirements
- R1: While reset is active and on the first cycle after it, `status` is 3'b000 and `irq` is 0. The bit positions are: bit 0 parity fault, bit 1 bus reset seen, bit 2 unexpected disconnect.
- R2: A `disc_evt` pulse while `is_initiator` is 0 never sets status bit 2, in either mode.
- R3: With `is_initiator`=1 and `script_mode`=1, a `disc_evt` does not set bit 2 when the most recent recorded message byte was 0x04 or 0x00. Any other recorded byte, or no recorded byte, sets bit 2 on the clock edge of the disconnect.
- R4: With `is_initiator`=1 and `script_mode`=0, every `disc_evt` sets bit 2, even one that follows byte 0x04.
- R5: A disconnect consumes the recorded message. A second disconnect with no new `msg_valid` between them is unexpected. Reset also clears the record. If `msg_valid` and `disc_evt` fall in the same cycle, the disconnect is judged by the older record and the new byte is kept for the next disconnect.
- R6: A rising edge of `bus_rst_raw` sets bit 1 three clock edges after the input changes (two synchronizer stages plus the status register). Keeping the line high sets the bit only once.
- R7: A rising edge of `local_rst_req` sets bit 1 on the next clock edge. While the request stays high, the bit does not set again.
- R8: `par_err` sets bit 0 only in a cycle where `par_chk_en` is 1.
- R9: `irq` equals the OR over i of `status[i] & irq_mask[i]`. The mask has no effect on `status`.
- R10: When `rd_clr` is 1 at a clock edge, all status bits clear. An event that sets a bit at that same edge leaves that bit set.
- R11: A set status bit stays set until an `rd_clr` edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| is_initiator | input | 1 | 1 = initiator role, 0 = target role |
| script_mode | input | 1 | 1 = script execution, 0 = low-level mode |
| msg_byte | input | 8 | Last received message byte |
| msg_valid | input | 1 | One-cycle strobe: `msg_byte` is valid |
| disc_evt | input | 1 | One-cycle strobe: target left the bus |
| bus_rst_raw | input | 1 | Asynchronous bus reset line, active high |
| local_rst_req | input | 1 | Reset driven by this controller, synchronous |
| par_err | input | 1 | Parity fault detected this cycle |
| par_chk_en | input | 1 | Parity checking enable |
| irq_mask | input | 3 | Per-bit interrupt enable, same positions as `status` |
| rd_clr | input | 1 | Status read strobe, clears all bits |
| status | output | 3 | Sticky event bits |
| irq | output | 1 | Interrupt request |

## Verification
Some properties are checked by assertions on every cycle. A disconnect bit can rise only after a disconnect seen in the initiator role. A parity bit can rise only when checking is enabled. Bits hold until a read. A read with no coincident event empties the register, and the request is never active without a set, enabled bit. Other behaviour shows only in the bench's scenarios: whether a disconnect is expected depends on the message history, the record is consumed by a disconnect, reset detection responds to the edge and not the level, and the synchronizer adds a fixed latency. The bench covers these with directed sequences, then compares against a reference model under random traffic.

// File: rtl/bev_pkg.sv
package bev_pkg;
  localparam int EVT_N   = 3;
  localparam int IDX_PAR = 0;
  localparam int IDX_RST = 1;
  localparam int IDX_UDC = 2;
  typedef logic [EVT_N-1:0] evt_vec_t;
endpackage

// File: rtl/bev_rst_edge.sv
module bev_rst_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_raw,
  input  logic local_req,
  output logic edge_evt
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic level, level_q;

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sync_q[g] <= 1'b0;
        else        sync_q[g] <= line_raw;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sync_q[g] <= 1'b0;
        else        sync_q[g] <= sync_q[g-1];
    end
  end

  // Either source of bus reset counts as one combined level
  assign level = sync_q[SYNC_STAGES-1] | local_req;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) level_q <= 1'b0;
    else        level_q <= level;

  assign edge_evt = level & ~level_q;

  // R6 / R7: a held level yields one event only
  assert_single_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    edge_evt |=> !edge_evt);
endmodule

// File: rtl/bev_disc_judge.sv
module bev_disc_judge #(
  parameter int             MSG_W     = 8,
  parameter logic [MSG_W-1:0] CODE_DISC = 8'h04,
  parameter logic [MSG_W-1:0] CODE_DONE = 8'h00
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             is_initiator,
  input  logic             script_mode,
  input  logic [MSG_W-1:0] msg_byte,
  input  logic             msg_valid,
  input  logic             disc_evt,
  output logic             udc_evt
);
  logic expect_q;
  logic byte_ok;

  assign byte_ok = (msg_byte == CODE_DISC) || (msg_byte == CODE_DONE);

  // Record is consumed by a disconnect; a new byte in the same cycle wins
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)         expect_q <= 1'b0;
    else if (msg_valid) expect_q <= byte_ok;
    else if (disc_evt)  expect_q <= 1'b0;

  assign udc_evt = disc_evt && is_initiator && (!script_mode || !expect_q);
endmodule

// File: rtl/bev_status_reg.sv
module bev_status_reg
  import bev_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  evt_vec_t set_vec,
  input  logic     rd_clr,
  input  evt_vec_t mask,
  output evt_vec_t status,
  output logic     irq
);
  evt_vec_t status_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) status_q <= '0;
    else        status_q <= (rd_clr ? '0 : status_q) | set_vec;

  assign status = status_q;
  assign irq    = |(status_q & mask);

  assert_clear_all_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && set_vec == '0) |=> (status == '0));

  for (genvar i = 0; i < EVT_N; i++) begin : g_chk
    assert_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (status[i] && !rd_clr) |=> status[i]);
  end

  assert_irq_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((status & mask) != '0));
endmodule

// File: rtl/bus_event_irq.sv
module bus_event_irq
  import bev_pkg::*;
#(
  parameter int MSG_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             is_initiator,
  input  logic             script_mode,
  input  logic [MSG_W-1:0] msg_byte,
  input  logic             msg_valid,
  input  logic             disc_evt,
  input  logic             bus_rst_raw,
  input  logic             local_rst_req,
  input  logic             par_err,
  input  logic             par_chk_en,
  input  logic [EVT_N-1:0] irq_mask,
  input  logic             rd_clr,
  output logic [EVT_N-1:0] status,
  output logic             irq
);
  logic     udc_evt, rst_evt;
  evt_vec_t set_vec;

  bev_disc_judge #(.MSG_W(MSG_W)) u_judge (
    .clk(clk), .rst_n(rst_n), .is_initiator(is_initiator),
    .script_mode(script_mode), .msg_byte(msg_byte), .msg_valid(msg_valid),
    .disc_evt(disc_evt), .udc_evt(udc_evt));

  bev_rst_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst_n(rst_n), .line_raw(bus_rst_raw),
    .local_req(local_rst_req), .edge_evt(rst_evt));

  always_comb begin
    set_vec          = '0;
    set_vec[IDX_UDC] = udc_evt;
    set_vec[IDX_RST] = rst_evt;
    set_vec[IDX_PAR] = par_err & par_chk_en;
  end

  bev_status_reg u_stat (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .rd_clr(rd_clr),
    .mask(irq_mask), .status(status), .irq(irq));

  assert_udc_initiator_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[IDX_UDC]) |-> $past(is_initiator && disc_evt));

  assert_par_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[IDX_PAR]) |-> $past(par_err && par_chk_en));
endmodule

// File: tb/bus_event_irq_test.sv
module bus_event_irq_test;
  logic clk = 0, rst_n = 0;
  logic is_initiator = 0, script_mode = 0, msg_valid = 0, disc_evt = 0;
  logic [7:0] msg_byte = 0;
  logic bus_rst_raw = 0, local_rst_req = 0, par_err = 0, par_chk_en = 0, rd_clr = 0;
  logic [2:0] irq_mask = 3'b111;
  logic [2:0] status;
  logic irq;
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  bus_event_irq uut (.*);

  // Reference model from the requirements
  logic [2:0] m_st = 0;
  logic m_exp = 0, m_s1 = 0, m_s2 = 0, m_prev = 0;
  always @(posedge clk) begin
    logic lvl, ok;
    logic [2:0] setv;
    if (!rst_n) begin
      m_st = 0; m_exp = 0; m_s1 = 0; m_s2 = 0; m_prev = 0;
    end else begin
      lvl     = m_s2 | local_rst_req;
      setv    = 0;
      setv[2] = disc_evt && is_initiator && (!script_mode || !m_exp);
      setv[1] = lvl && !m_prev;
      setv[0] = par_err && par_chk_en;
      m_st    = (rd_clr ? 3'b000 : m_st) | setv;
      ok      = (msg_byte == 8'h04) || (msg_byte == 8'h00);
      if (msg_valid) m_exp = ok; else if (disc_evt) m_exp = 0;
      m_prev = lvl; m_s2 = m_s1; m_s1 = bus_rst_raw;
    end
  end

  function automatic logic irq_of(logic [2:0] s, logic [2:0] m);
    return |(s & m);
  endfunction

  task automatic tick(int n = 1);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic chk(string req, logic [3:0] got, logic [3:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  task automatic chk_st(string req, logic [2:0] exp);
    chk(req, {irq, status}, {irq_of(exp, irq_mask), exp});
  endtask

  task automatic clear();
    rd_clr = 1; tick(); rd_clr = 0;
  endtask

  task automatic send_msg(logic [7:0] b);
    msg_byte = b; msg_valid = 1; tick(); msg_valid = 0;
  endtask

  task automatic disc();
    disc_evt = 1; tick(); disc_evt = 0;
  endtask

  initial begin
    #1;
    chk_st("R1 in reset", 3'b000);
    tick(2); rst_n = 1; tick();
    chk_st("R1 after reset", 3'b000);

    // R4 low-level: every disconnect flagged
    is_initiator = 1; script_mode = 0;
    send_msg(8'h04); disc();
    chk_st("R4 low-level disc", 3'b100);
    clear(); chk_st("R10 clear", 3'b000);

    // R3 script mode
    script_mode = 1;
    send_msg(8'h04); disc(); chk_st("R3 after 0x04", 3'b000);
    send_msg(8'h00); disc(); chk_st("R3 after 0x00", 3'b000);
    send_msg(8'h12); disc(); chk_st("R3 after 0x12", 3'b100);
    clear();
    // R5 record consumed
    send_msg(8'h04); disc(); chk_st("R5 first disc", 3'b000);
    disc(); chk_st("R5 second disc", 3'b100);
    clear();
    // R5 same-cycle msg and disc: judged by old (empty) record, new byte kept
    msg_byte = 8'h04; msg_valid = 1; disc_evt = 1; tick(); msg_valid = 0; disc_evt = 0;
    chk_st("R5 same cycle judged old", 3'b100);
    clear(); disc(); chk_st("R5 same cycle byte kept", 3'b000);

    // R2 target mode ignored
    is_initiator = 0; script_mode = 1; disc(); chk_st("R2 target script", 3'b000);
    script_mode = 0; disc(); chk_st("R2 target low-level", 3'b000);

    // R8 parity gating
    par_err = 1; par_chk_en = 0; tick(); par_err = 0;
    chk_st("R8 disabled", 3'b000);
    par_err = 1; par_chk_en = 1; tick(); par_err = 0;
    chk_st("R8 enabled", 3'b001);
    // R11 sticky
    tick(5); chk_st("R11 sticky", 3'b001);
    // R9 mask
    irq_mask = 3'b000; #1; chk_st("R9 mask none", 3'b001);
    irq_mask = 3'b110; #1; chk_st("R9 mask other", 3'b001);
    irq_mask = 3'b001; #1; chk_st("R9 mask match", 3'b001);
    irq_mask = 3'b111; clear();

    // R6 bus reset edge with sync latency
    bus_rst_raw = 1;
    tick(); chk_st("R6 latency 1", 3'b000);
    tick(); chk_st("R6 latency 2", 3'b000);
    tick(); chk_st("R6 latency 3", 3'b010);
    clear(); tick(10); chk_st("R6 held level", 3'b000);
    bus_rst_raw = 0; tick(4);
    bus_rst_raw = 1; tick(3); chk_st("R6 second edge", 3'b010);
    bus_rst_raw = 0; clear(); tick(4);

    // R7 local request
    local_rst_req = 1; tick(); chk_st("R7 local edge", 3'b010);
    clear(); tick(5); chk_st("R7 local held", 3'b000);
    local_rst_req = 0; tick(2);

    // R10 set coincident with clear
    is_initiator = 1; script_mode = 0; disc(); chk_st("R10 pre", 3'b100);
    rd_clr = 1; par_err = 1; tick(); rd_clr = 0; par_err = 0;
    chk_st("R10 set survives clear", 3'b001);

    // Random phase against the model
    rst_n = 0; tick(2); rst_n = 1; tick();
    void'($urandom(32'h5eed_1234));
    for (int c = 0; c < 4000; c++) begin
      logic [2:0] sel;
      sel = 3'($urandom_range(0, 7));
      is_initiator  = ($urandom_range(0, 3) != 0);
      script_mode   = ($urandom_range(0, 3) != 0);
      msg_valid     = ($urandom_range(0, 3) == 0);
      msg_byte      = (sel < 3) ? 8'h04 : (sel < 5) ? 8'h00 : 8'($urandom);
      disc_evt      = ($urandom_range(0, 4) == 0);
      if ($urandom_range(0, 15) == 0) bus_rst_raw = ~bus_rst_raw;
      if ($urandom_range(0, 11) == 0) local_rst_req = ~local_rst_req;
      par_err       = ($urandom_range(0, 5) == 0);
      par_chk_en    = ($urandom_range(0, 1) == 0);
      rd_clr        = ($urandom_range(0, 6) == 0);
      if ($urandom_range(0, 19) == 0) irq_mask = 3'($urandom);
      tick();
      chk_st("R2-R11 random model", m_st);
    end
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule